// File: doc/BRIEF.md
# Multicycle processor control sequencer

This block is the hardwired control unit of a multicycle 32-bit processor in which one ALU and one memory port are shared by every step of an instruction. It holds a state register and drives every datapath strobe and multiplexer select straight from that register, so the outputs are Moore outputs. The outputs cover register-file writes, the ALU operand and operation selects, memory reads and writes, the instruction-register load and the PC update. The inputs are the opcode field of the instruction register and the ALU overflow flag. The datapath itself lies outside the block.

Each instruction passes through a fetch state and a decode state, and then through a short completion path chosen by the opcode. These paths cover register-register ALU operations, word load, word store, branch-if-equal and jump. Two trap states handle an unknown opcode and an arithmetic overflow. Each trap state uses the ALU to compute PC minus 4 for the saved-PC register, records a 1-bit cause, and steers the PC to the fixed handler address. Every path, trap states included, ends by returning to fetch.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 0 (fetch), whatever the inputs are; `state_o` shows the state code.
- R2: State 0 asserts mem_rd, ir_wr and pc_wr with alu_src_b=01 (constant 4), alu_op=00 (add), alu_src_a=0, i_or_d=0 and pc_src=00. The next state is always 1.
- R3: State 1 drives alu_src_a=0, alu_src_b=11 (shifted immediate) and alu_op=00, with no strobe asserted. The next state is chosen by opcode: 0x00 gives 6, 0x23 gives 2, 0x2B gives 2, 0x04 gives 8 and 0x02 gives 9.
- R4: State 2 drives alu_src_a=1, alu_src_b=10 and alu_op=00. For opcode 0x23 the sequence continues through 3 (mem_rd, i_or_d=1) and 4 (reg_wr, mem_to_reg=1, reg_dst=0), then returns to 0.
- R5: For opcode 0x2B, state 2 is followed by state 5 (mem_wr, i_or_d=1) and then by state 0.
- R6: State 6 drives alu_src_a=1, alu_src_b=00 and alu_op=10 (function field). Without overflow it is followed by state 7 (reg_wr, reg_dst=1, mem_to_reg=0) and then by state 0.
- R7: State 8 drives alu_src_a=1, alu_src_b=00, alu_op=01 (subtract), pc_wr_cond and pc_src=01, with pc_wr low. It is followed by state 0.
- R8: State 9 asserts pc_wr with pc_src=10 (jump target). It is followed by state 0.
- R9: Any other opcode seen in state 1 leads to state 10. State 10 asserts epc_wr, cause_wr and pc_wr, with cause_val=0, pc_src=11 (handler address), alu_src_a=0, alu_src_b=01 and alu_op=01. It is followed by state 0.
- R10: alu_ovf high in state 6 leads to state 11 instead of 7. State 11 drives the same outputs as state 10 except cause_val=1, and reg_wr stays low. It is followed by state 0.
- R11: Every one-bit output not named for a state is 0 in that state, and every 2-bit select not named is 00.
- R12: alu_ovf has no effect on the next state in any state other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU arithmetic overflow flag |
| reg_dst | output | 1 | Write-register select: 1 picks rd, 0 picks rt |
| reg_wr | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_to_reg | output | 1 | Write-back data: 1 memory data register, 0 ALU result register |
| i_or_d | output | 1 | Memory address: 0 PC, 1 ALU result register |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the ALU zero flag |
| alu_op | output | 2 | 00 add, 01 subtract, 10 by function field |
| alu_src_b | output | 2 | 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| pc_src | output | 2 | 00 ALU, 01 ALU result register, 10 jump target, 11 handler address |
| epc_wr | output | 1 | Saved-PC register write |
| cause_wr | output | 1 | Cause register write |
| cause_val | output | 1 | Cause code: 0 unknown opcode, 1 overflow |
| state_o | output | 4 | Current state code |

## Verification
The bench builds the block with its default opcode assignments. It sweeps all 64 opcode values, each with the overflow flag held low and then held high for the whole instruction. This reaches every state. It also reaches every illegal opcode, both outcomes of the execute state, and overflow asserted in states where it must be ignored. At each cycle the bench compares the state code and the complete output vector against a model written from the requirements. A reset asserted in the middle of a load confirms that reset returns the block to fetch.

// File: rtl/mc_ctrl_pkg.sv
// Package: state codes and the control word shared by the control sequencer.
// Assumes a 4-bit state encoding; the codes are visible at the top module.
package mc_ctrl_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_ADDR   = 4'd2,
        S_LDMEM  = 4'd3,
        S_LDWB   = 4'd4,
        S_STMEM  = 4'd5,
        S_EXEC   = 4'd6,
        S_RWB    = 4'd7,
        S_BEQ    = 4'd8,
        S_JMP    = 4'd9,
        S_XUND   = 4'd10,
        S_XOVF   = 4'd11
    } state_t;

    // ALU operation select codes
    localparam logic [1:0] ALU_ADD  = 2'b00;
    localparam logic [1:0] ALU_SUB  = 2'b01;
    localparam logic [1:0] ALU_FUNC = 2'b10;

    // ALU operand B select codes
    localparam logic [1:0] SRCB_REG  = 2'b00;
    localparam logic [1:0] SRCB_FOUR = 2'b01;
    localparam logic [1:0] SRCB_IMM  = 2'b10;
    localparam logic [1:0] SRCB_IMM4 = 2'b11;

    // PC source select codes
    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_OUT  = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;
    localparam logic [1:0] PCS_TRAP = 2'b11;

    typedef struct packed {
        logic       reg_dst;
        logic       reg_wr;
        logic       alu_src_a;
        logic       mem_rd;
        logic       mem_wr;
        logic       mem_to_reg;
        logic       i_or_d;
        logic       ir_wr;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] alu_op;
        logic [1:0] alu_src_b;
        logic [1:0] pc_src;
        logic       epc_wr;
        logic       cause_wr;
        logic       cause_val;
    } ctl_t;

endpackage

// File: rtl/mc_ctrl_sreg.sv
// State register of the control sequencer.
// Assumes a synchronous active-low reset that forces the fetch state.
module mc_ctrl_sreg
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t d,
    output state_t q
);

    // Hold the current state, reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= S_FETCH;
        else        q <= d;
    end

endmodule

// File: rtl/mc_ctrl_next.sv
// Next-state logic: fixed steps, opcode dispatch in decode, overflow
// diversion in execute. Assumes the opcode stays stable through decode.
module mc_ctrl_next
    import mc_ctrl_pkg::*;
#(
    parameter int               OP_W     = 6,
    parameter logic [OP_W-1:0]  OP_RTYPE = 6'h00,
    parameter logic [OP_W-1:0]  OP_LW    = 6'h23,
    parameter logic [OP_W-1:0]  OP_SW    = 6'h2B,
    parameter logic [OP_W-1:0]  OP_BEQ   = 6'h04,
    parameter logic [OP_W-1:0]  OP_J     = 6'h02
) (
    input  state_t          cur,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    output state_t          nxt
);

    // Choose the successor of the current state.
    always_comb begin
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                if      (opcode == OP_RTYPE) nxt = S_EXEC;
                else if (opcode == OP_LW)    nxt = S_ADDR;
                else if (opcode == OP_SW)    nxt = S_ADDR;
                else if (opcode == OP_BEQ)   nxt = S_BEQ;
                else if (opcode == OP_J)     nxt = S_JMP;
                else                         nxt = S_XUND;
            end
            S_ADDR:   nxt = (opcode == OP_SW) ? S_STMEM : S_LDMEM;
            S_LDMEM:  nxt = S_LDWB;
            S_EXEC:   nxt = alu_ovf ? S_XOVF : S_RWB;
            default:  nxt = S_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_decode.sv
// Output decoder: maps the state to the full control word (Moore outputs).
// Assumes any strobe or select not named for a state is zero.
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_t cur,
    output ctl_t   ctl
);

    // Build the control word for the current state.
    always_comb begin
        ctl = '0;
        unique case (cur)
            S_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_src_b = SRCB_FOUR;
                ctl.alu_op    = ALU_ADD;
                ctl.pc_src    = PCS_ALU;
            end
            S_DECODE: ctl.alu_src_b = SRCB_IMM4;
            S_ADDR: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_IMM;
            end
            S_LDMEM: begin
                ctl.mem_rd = 1'b1;
                ctl.i_or_d = 1'b1;
            end
            S_LDWB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            S_STMEM: begin
                ctl.mem_wr = 1'b1;
                ctl.i_or_d = 1'b1;
            end
            S_EXEC: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_op    = ALU_FUNC;
            end
            S_RWB: begin
                ctl.reg_dst = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            S_BEQ: begin
                ctl.alu_src_a  = 1'b1;
                ctl.alu_op     = ALU_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PCS_OUT;
            end
            S_JMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JMP;
            end
            S_XUND, S_XOVF: begin
                ctl.alu_src_b = SRCB_FOUR;
                ctl.alu_op    = ALU_SUB;
                ctl.epc_wr    = 1'b1;
                ctl.cause_wr  = 1'b1;
                ctl.cause_val = (cur == S_XOVF);
                ctl.pc_wr     = 1'b1;
                ctl.pc_src    = PCS_TRAP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
// Top of the multicycle control sequencer: state register, next-state
// logic and output decoder. Assumes the datapath samples every output
// on the same rising edge that advances the state.
module mc_ctrl
    import mc_ctrl_pkg::*;
#(
    parameter int               OP_W     = 6,
    parameter logic [OP_W-1:0]  OP_RTYPE = 6'h00,
    parameter logic [OP_W-1:0]  OP_LW    = 6'h23,
    parameter logic [OP_W-1:0]  OP_SW    = 6'h2B,
    parameter logic [OP_W-1:0]  OP_BEQ   = 6'h04,
    parameter logic [OP_W-1:0]  OP_J     = 6'h02
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_ovf,
    output logic               reg_dst,
    output logic               reg_wr,
    output logic               alu_src_a,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               mem_to_reg,
    output logic               i_or_d,
    output logic               ir_wr,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic [1:0]         alu_op,
    output logic [1:0]         alu_src_b,
    output logic [1:0]         pc_src,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic               cause_val,
    output logic [STATE_W-1:0] state_o
);

    state_t cur_q;
    state_t nxt_d;
    ctl_t   ctl;

    mc_ctrl_sreg u_sreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_d),
        .q     (cur_q)
    );

    mc_ctrl_next #(
        .OP_W     (OP_W),
        .OP_RTYPE (OP_RTYPE),
        .OP_LW    (OP_LW),
        .OP_SW    (OP_SW),
        .OP_BEQ   (OP_BEQ),
        .OP_J     (OP_J)
    ) u_next (
        .cur     (cur_q),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .nxt     (nxt_d)
    );

    mc_ctrl_decode u_dec (
        .cur (cur_q),
        .ctl (ctl)
    );

    // Fan the control word out to the ports.
    always_comb begin
        reg_dst    = ctl.reg_dst;
        reg_wr     = ctl.reg_wr;
        alu_src_a  = ctl.alu_src_a;
        mem_rd     = ctl.mem_rd;
        mem_wr     = ctl.mem_wr;
        mem_to_reg = ctl.mem_to_reg;
        i_or_d     = ctl.i_or_d;
        ir_wr      = ctl.ir_wr;
        pc_wr      = ctl.pc_wr;
        pc_wr_cond = ctl.pc_wr_cond;
        alu_op     = ctl.alu_op;
        alu_src_b  = ctl.alu_src_b;
        pc_src     = ctl.pc_src;
        epc_wr     = ctl.epc_wr;
        cause_wr   = ctl.cause_wr;
        cause_val  = ctl.cause_val;
        state_o    = cur_q;
    end

endmodule

// File: rtl/mc_ctrl_chk.sv
// Checker for the control sequencer, attached by bind. It observes ports only.
module mc_ctrl_chk #(
    parameter int               OP_W     = 6,
    parameter logic [OP_W-1:0]  OP_RTYPE = 6'h00,
    parameter logic [OP_W-1:0]  OP_LW    = 6'h23,
    parameter logic [OP_W-1:0]  OP_SW    = 6'h2B,
    parameter logic [OP_W-1:0]  OP_BEQ   = 6'h04,
    parameter logic [OP_W-1:0]  OP_J     = 6'h02
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] opcode,
    input logic            alu_ovf,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            i_or_d,
    input logic            pc_wr,
    input logic            pc_wr_cond,
    input logic [1:0]      alu_op,
    input logic [1:0]      pc_src,
    input logic            epc_wr,
    input logic            cause_wr,
    input logic            cause_val,
    input logic [3:0]      state_o
);

    logic op_known;
    assign op_known = (opcode == OP_RTYPE) || (opcode == OP_LW) || (opcode == OP_SW)
                   || (opcode == OP_BEQ) || (opcode == OP_J);

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0) |=> (state_o == 4'd1));

    // R9
    undef_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && !op_known) |=> (epc_wr && cause_wr && !cause_val && pc_src == 2'b11));

    // R10
    ovf_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd6 && alu_ovf) |=> (epc_wr && cause_wr && cause_val && pc_wr));

    // R12
    addr_ignores_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd2) |=> (state_o == 4'd3 || state_o == 4'd5));

    // R7
    cond_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |-> (pc_src == 2'b01 && alu_op == 2'b01 && !pc_wr));

    // R11
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    // R5
    store_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> i_or_d);

endmodule

bind mc_ctrl mc_ctrl_chk #(
    .OP_W     (OP_W),
    .OP_RTYPE (OP_RTYPE),
    .OP_LW    (OP_LW),
    .OP_SW    (OP_SW),
    .OP_BEQ   (OP_BEQ),
    .OP_J     (OP_J)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .alu_ovf    (alu_ovf),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .i_or_d     (i_or_d),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .alu_op     (alu_op),
    .pc_src     (pc_src),
    .epc_wr     (epc_wr),
    .cause_wr   (cause_wr),
    .cause_val  (cause_val),
    .state_o    (state_o)
);

// File: tb/tb_mc_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps every opcode with overflow low and high, checking the state
// and the whole control word every cycle against a model of the requirements.
module tb_mc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       alu_ovf;
    logic       reg_dst, reg_wr, alu_src_a, mem_rd, mem_wr, mem_to_reg;
    logic       i_or_d, ir_wr, pc_wr, pc_wr_cond;
    logic [1:0] alu_op, alu_src_b, pc_src;
    logic       epc_wr, cause_wr, cause_val;
    logic [3:0] state_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_ovf(alu_ovf),
        .reg_dst(reg_dst), .reg_wr(reg_wr), .alu_src_a(alu_src_a),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_to_reg(mem_to_reg),
        .i_or_d(i_or_d), .ir_wr(ir_wr), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
        .alu_op(alu_op), .alu_src_b(alu_src_b), .pc_src(pc_src),
        .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_val(cause_val),
        .state_o(state_o)
    );

    logic [18:0] act_ctl;
    assign act_ctl = {reg_dst, reg_wr, alu_src_a, mem_rd, mem_wr, mem_to_reg,
                      i_or_d, ir_wr, pc_wr, pc_wr_cond, alu_op, alu_src_b,
                      pc_src, epc_wr, cause_wr, cause_val};

    // Expected control word per state, written from the requirements.
    function automatic logic [18:0] exp_ctl(int s);
        logic rd = 0, rw = 0, sa = 0, mr = 0, mw = 0, m2r = 0, iod = 0, irw = 0;
        logic pw = 0, pwc = 0, ew = 0, cw = 0, cv = 0;
        logic [1:0] op = 0, sb = 0, ps = 0;
        case (s)
            0:  begin mr = 1; irw = 1; pw = 1; sb = 2'b01; end
            1:  sb = 2'b11;
            2:  begin sa = 1; sb = 2'b10; end
            3:  begin mr = 1; iod = 1; end
            4:  begin rw = 1; m2r = 1; end
            5:  begin mw = 1; iod = 1; end
            6:  begin sa = 1; op = 2'b10; end
            7:  begin rd = 1; rw = 1; end
            8:  begin sa = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10, 11: begin sb = 2'b01; op = 2'b01; ew = 1; cw = 1; pw = 1;
                          ps = 2'b11; cv = (s == 11); end
            default: ;
        endcase
        return {rd, rw, sa, mr, mw, m2r, iod, irw, pw, pwc, op, sb, ps, ew, cw, cv};
    endfunction

    // Expected successor state.
    function automatic int exp_next(int s, int op, bit ov);
        case (s)
            0: return 1;
            1: case (op)
                   'h00: return 6;
                   'h23, 'h2B: return 2;
                   'h04: return 8;
                   'h02: return 9;
                   default: return 10;
               endcase
            2: return (op == 'h2B) ? 5 : 3;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    function automatic string tag(int s, bit ov);
        string t;
        case (s)
            0: t = "R2"; 1: t = "R3"; 2, 3, 4: t = "R4"; 5: t = "R5";
            6, 7: t = "R6"; 8: t = "R7"; 9: t = "R8"; 10: t = "R9";
            11: t = "R10"; default: t = "R11";
        endcase
        if (ov && s != 6 && s != 11) t = {t, " R12"};
        return {t, " R11"};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s;
        int steps;
        rst_n = 1'b0; opcode = 6'h04; alu_ovf = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 state", 32'(state_o), 32'd0);
        check("R1 outputs", 32'(act_ctl), 32'(exp_ctl(0)));
        rst_n = 1'b1;

        for (int op = 0; op < 64; op++) begin
            for (int ov = 0; ov < 2; ov++) begin
                opcode = 6'(op); alu_ovf = ov[0];
                s = 0; steps = 0;
                do begin
                    check({tag(s, ov[0]), " state"}, 32'(state_o), 32'(s));
                    check({tag(s, ov[0]), " outputs"}, 32'(act_ctl), 32'(exp_ctl(s)));
                    @(posedge clk);
                    s = exp_next(s, op, ov[0]);
                    @(negedge clk);
                    steps++;
                end while (s != 0 && steps < 8);
            end
        end

        // R1: reset in the middle of a load returns to fetch
        opcode = 6'h23; alu_ovf = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 state before reset", 32'(state_o), 32'd2);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run state", 32'(state_o), 32'd0);
        check("R1 mid-run outputs", 32'(act_ctl), 32'(exp_ctl(0)));
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset", 32'(state_o), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule